// File: doc/BRIEF.md
# Sampled Logic Trigger Detector

This block watches a 16-channel logic sample stream, one sample per clock in which the sample-enable input is high. It produces a single-cycle trigger pulse when a programmed condition is met. In normal mode the condition is a level match over all channels, combined with up to two edge-detect units whose results are ORed. Each unit watches one channel for a rising and/or falling transition between consecutive accepted samples.

In fast mode the level and edge settings are ignored. One selected pin is watched for a single transition of a chosen polarity. All configuration arrives on plain input ports and is expected to stay steady while the detector is armed.

Software arms the detector with a one-cycle arm pulse. After the trigger fires, the detector holds a triggered flag and stays silent until it is armed again.

Top module: `trg_detect`

## Requirements
- R1: In normal mode with no edge channel configured, an accepted sample fires when (sample AND level_mask) equals level_value. The trigger pulse is high in the cycle after the clock edge that accepts the sample.
- R2: A level_value bit set outside level_mask makes the level condition unsatisfiable, so no trigger fires.
- R3: A channel set in rise_mask fires its edge unit when that channel was 0 in the previous accepted sample and is 1 in the current one.
- R4: A channel set in fall_mask fires its edge unit on a 1-to-0 transition. A channel set in both masks fires on either transition.
- R5: Edge units are assigned to the two lowest-numbered channels set in (rise_mask OR fall_mask), and their hits are ORed. Any further channel set in those masks has no effect.
- R6: In normal mode the trigger is the level match ANDed with the edge result whenever at least one edge channel is configured.
- R7: When fast_mode is 1, the pin number is fast_sel bits 2:0, and fast_sel bit 3 selects a falling edge (0 means rising). The level mask and value and the edge masks are ignored in this mode.
- R8: The first accepted sample after arming cannot produce an edge hit. The previous sample is taken only from cycles with the sample enable high.
- R9: After a trigger, triggered stays 1 and watching stays 0 until the next arm. No further pulse is produced in that time.
- R10: After reset, trig_pulse, triggered and watching are 0, and matching samples produce no pulse until the detector is armed.
- R11: An arm pulse sets watching and clears triggered in the next cycle. A sample presented in the arm cycle is not evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle arm request |
| smp_valid_i | input | 1 | Sample enable |
| smp_data_i | input | 16 | Sampled channel values |
| fast_mode_i | input | 1 | 1 selects single-pin fast mode |
| fast_sel_i | input | 4 | Fast pin (bits 2:0) and falling select (bit 3) |
| level_mask_i | input | 16 | Channels taking part in the level match |
| level_value_i | input | 16 | Required values for the level match |
| rise_mask_i | input | 16 | Channels to watch for rising edges |
| fall_mask_i | input | 16 | Channels to watch for falling edges |
| trig_pulse_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Latched trigger status |
| watching_o | output | 1 | Armed and waiting for the condition |

## Verification
Every result is registered once. The pulse, the triggered flag and the watching flag all change in the cycle after the edge that accepts a sample or an arm request. The bench drives each input on a falling edge, lets one rising edge pass, and samples on the following falling edge, where the new value has settled. Edge tests present two accepted samples and check after each one, so both the silent first sample and the hit on the second are observed in their own cycle.

// File: rtl/trg_pkg.sv
package trg_pkg;
    localparam int TRG_CHANNELS   = 16;
    localparam int TRG_EDGE_UNITS = 2;
    localparam int TRG_PIN_BITS   = 3;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_FAST   = 1'b1
    } trg_mode_e;
endpackage

// File: rtl/trg_level_match.sv
module trg_level_match #(
    parameter int CH = 16
) (
    input  logic [CH-1:0] cur_i,
    input  logic [CH-1:0] mask_i,
    input  logic [CH-1:0] value_i,
    output logic          match_o
);
    logic [CH-1:0] masked;

    always_comb begin
        masked  = cur_i & mask_i;
        match_o = (masked == value_i);
    end
endmodule

// File: rtl/trg_edge_unit.sv
module trg_edge_unit #(
    parameter int CH       = 16,
    parameter int UNIT_IDX = 0
) (
    input  logic [CH-1:0] cur_i,
    input  logic [CH-1:0] prev_i,
    input  logic [CH-1:0] rise_mask_i,
    input  logic [CH-1:0] fall_mask_i,
    output logic          used_o,
    output logic          hit_o
);
    localparam int IDX_W = (CH > 1) ? $clog2(CH) : 1;
    localparam int CNT_W = $clog2(CH + 1);

    logic [CH-1:0]    watch;
    logic [IDX_W-1:0] sel;
    logic             found;
    logic [CNT_W-1:0] seen;
    logic             rose;
    logic             fell;

    // Pick the UNIT_IDX-th lowest channel that has any edge request.
    always_comb begin
        watch = rise_mask_i | fall_mask_i;
        sel   = '0;
        found = 1'b0;
        seen  = '0;
        for (int i = 0; i < CH; i++) begin
            if (watch[i]) begin
                if (!found && (int'(seen) == UNIT_IDX)) begin
                    sel   = IDX_W'(i);
                    found = 1'b1;
                end
                seen = seen + 1'b1;
            end
        end
    end

    always_comb begin
        rose   = ~prev_i[sel] &  cur_i[sel];
        fell   =  prev_i[sel] & ~cur_i[sel];
        used_o = found;
        hit_o  = found & ((rise_mask_i[sel] & rose) | (fall_mask_i[sel] & fell));
    end
endmodule

// File: rtl/trg_fast_edge.sv
module trg_fast_edge #(
    parameter int CH       = 16,
    parameter int PIN_BITS = 3
) (
    input  logic [CH-1:0]     cur_i,
    input  logic [CH-1:0]     prev_i,
    input  logic [PIN_BITS:0] sel_i,
    output logic              hit_o
);
    logic [PIN_BITS-1:0] pin;
    logic                want_fall;
    logic                now_bit;
    logic                was_bit;

    always_comb begin
        pin       = sel_i[PIN_BITS-1:0];
        want_fall = sel_i[PIN_BITS];
        now_bit   = cur_i[pin];
        was_bit   = prev_i[pin];
        hit_o     = want_fall ? (was_bit & ~now_bit) : (~was_bit & now_bit);
    end
endmodule

// File: rtl/trg_detect.sv
module trg_detect
    import trg_pkg::*;
#(
    parameter int CH         = trg_pkg::TRG_CHANNELS,
    parameter int EDGE_UNITS = trg_pkg::TRG_EDGE_UNITS,
    parameter int PIN_BITS   = trg_pkg::TRG_PIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              smp_valid_i,
    input  logic [CH-1:0]     smp_data_i,
    input  logic              fast_mode_i,
    input  logic [PIN_BITS:0] fast_sel_i,
    input  logic [CH-1:0]     level_mask_i,
    input  logic [CH-1:0]     level_value_i,
    input  logic [CH-1:0]     rise_mask_i,
    input  logic [CH-1:0]     fall_mask_i,
    output logic              trig_pulse_o,
    output logic              triggered_o,
    output logic              watching_o
);
    typedef struct packed {
        logic          armed;
        logic          triggered;
        logic          pulse;
        logic          have_prev;
        logic [CH-1:0] prev;
    } det_state_t;

    det_state_t st_d, st_q;

    trg_mode_e         mode;
    logic              level_ok;
    logic [EDGE_UNITS-1:0] unit_used;
    logic [EDGE_UNITS-1:0] unit_hit;
    logic              fast_hit;
    logic              normal_hit;
    logic              edge_ok;
    logic              cond_hit;
    logic              fire;

    trg_level_match #(.CH(CH)) level_i (
        .cur_i   (smp_data_i),
        .mask_i  (level_mask_i),
        .value_i (level_value_i),
        .match_o (level_ok)
    );

    for (genvar u = 0; u < EDGE_UNITS; u++) begin : g_edge
        trg_edge_unit #(.CH(CH), .UNIT_IDX(u)) edge_i (
            .cur_i       (smp_data_i),
            .prev_i      (st_q.prev),
            .rise_mask_i (rise_mask_i),
            .fall_mask_i (fall_mask_i),
            .used_o      (unit_used[u]),
            .hit_o       (unit_hit[u])
        );
    end

    trg_fast_edge #(.CH(CH), .PIN_BITS(PIN_BITS)) fast_i (
        .cur_i  (smp_data_i),
        .prev_i (st_q.prev),
        .sel_i  (fast_sel_i),
        .hit_o  (fast_hit)
    );

    always_comb begin
        mode       = trg_mode_e'(fast_mode_i);
        edge_ok    = (|unit_used) ? (st_q.have_prev & (|unit_hit)) : 1'b1;
        normal_hit = level_ok & edge_ok;
        cond_hit   = (mode == MODE_FAST) ? (st_q.have_prev & fast_hit) : normal_hit;
        fire       = st_q.armed & smp_valid_i & ~arm_i & cond_hit;

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (arm_i) begin
            st_d.armed     = 1'b1;
            st_d.triggered = 1'b0;
            st_d.have_prev = 1'b0;
        end else if (smp_valid_i) begin
            st_d.prev      = smp_data_i;
            st_d.have_prev = 1'b1;
            if (fire) begin
                st_d.armed     = 1'b0;
                st_d.triggered = 1'b1;
                st_d.pulse     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_pulse_o = st_q.pulse;
    assign triggered_o  = st_q.triggered;
    assign watching_o   = st_q.armed;
endmodule

// File: rtl/trg_detect_chk.sv
module trg_detect_chk #(
    parameter int CH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic          smp_valid_i,
    input logic [CH-1:0] smp_data_i,
    input logic          fast_mode_i,
    input logic [CH-1:0] level_mask_i,
    input logic [CH-1:0] level_value_i,
    input logic          trig_pulse_o,
    input logic          triggered_o,
    input logic          watching_o
);
    a_r9_pulse_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse_o |-> triggered_o);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse_o |=> !trig_pulse_o);

    a_r9_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered_o && !arm_i) |=> triggered_o);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(triggered_o && watching_o));

    a_r11_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (watching_o && !triggered_o && !trig_pulse_o));

    a_r10_needs_watch: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !arm_i && !watching_o) |=> !trig_pulse_o);

    a_r1_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !arm_i && !fast_mode_i &&
         ((smp_data_i & level_mask_i) != level_value_i)) |=> !trig_pulse_o);
endmodule

bind trg_detect trg_detect_chk #(.CH(CH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm_i         (arm_i),
    .smp_valid_i   (smp_valid_i),
    .smp_data_i    (smp_data_i),
    .fast_mode_i   (fast_mode_i),
    .level_mask_i  (level_mask_i),
    .level_value_i (level_value_i),
    .trig_pulse_o  (trig_pulse_o),
    .triggered_o   (triggered_o),
    .watching_o    (watching_o)
);

// File: tb/trg_detect_tb.sv
module trg_detect_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        valid = 1'b0;
    logic [15:0] data = '0;
    logic        fast = 1'b0;
    logic [3:0]  fsel = '0;
    logic [15:0] lmask = '0;
    logic [15:0] lval = '0;
    logic [15:0] rmask = '0;
    logic [15:0] fmask = '0;
    logic        pulse;
    logic        trig;
    logic        watch;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trg_detect dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_i         (arm),
        .smp_valid_i   (valid),
        .smp_data_i    (data),
        .fast_mode_i   (fast),
        .fast_sel_i    (fsel),
        .level_mask_i  (lmask),
        .level_value_i (lval),
        .rise_mask_i   (rmask),
        .fall_mask_i   (fmask),
        .trig_pulse_o  (pulse),
        .triggered_o   (trig),
        .watching_o    (watch)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic do_arm();
        arm = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic send(input logic [15:0] d, input logic exp, input string req);
        valid = 1'b1;
        data  = d;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        check(pulse, exp, req);
    endtask

    task automatic set_cfg(input logic f, input logic [3:0] fs, input logic [15:0] lm,
                           input logic [15:0] lv, input logic [15:0] rm, input logic [15:0] fm);
        fast = f; fsel = fs; lmask = lm; lval = lv; rmask = rm; fmask = fm;
    endtask

    // Arm, present p then c; the first must be silent, the second gives exp.
    task automatic pair(input logic [15:0] p, input logic [15:0] c, input logic exp, input string req);
        do_arm();
        send(p, 1'b0, {req, " first sample"});
        if (!trig) send(c, exp, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state, then no firing while unarmed
        check(pulse, 1'b0, "R10 reset pulse");
        check(trig, 1'b0, "R10 reset triggered");
        check(watch, 1'b0, "R10 reset watching");
        set_cfg(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        send(16'h1234, 1'b0, "R10 unarmed");
        check(trig, 1'b0, "R10 unarmed status");

        // R1: sweep level value and sample nibble on channels 7:4
        for (int v = 0; v < 16; v++) begin
            for (int s = 0; s < 16; s++) begin
                set_cfg(1'b0, 4'h0, 16'h00F0, 16'(v << 4), 16'h0000, 16'h0000);
                do_arm();
                send(16'hA50A | 16'(s << 4), (s == v), "R1 level sweep");
            end
        end

        // R2: value bit outside mask
        set_cfg(1'b0, 4'h0, 16'h00F0, 16'h01F0, 16'h0000, 16'h0000);
        do_arm();
        send(16'h01F0, 1'b0, "R2 value outside mask");
        send(16'hFFFF, 1'b0, "R2 value outside mask all ones");

        // R3 / R4: all prev/cur combinations on one channel
        for (int pc = 0; pc < 4; pc++) begin
            logic pb, cb;
            pb = pc[1]; cb = pc[0];
            set_cfg(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0020, 16'h0000);
            pair(16'(pb) << 5, 16'(cb) << 5, (!pb && cb), "R3 rising ch5");
            set_cfg(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0200);
            pair(16'(pb) << 9, 16'(cb) << 9, (pb && !cb), "R4 falling ch9");
            set_cfg(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0200, 16'h0200);
            pair(16'(pb) << 9, 16'(cb) << 9, (pb != cb), "R4 both edges ch9");
        end

        // R5: two units ORed, third channel ignored
        set_cfg(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h4004, 16'h0800);
        pair(16'h0000, 16'h0004, 1'b1, "R5 unit0 rise ch2");
        pair(16'h0800, 16'h0000, 1'b1, "R5 unit1 fall ch11");
        pair(16'h0000, 16'h4000, 1'b0, "R5 third channel ignored");

        // R6: level AND edge
        set_cfg(1'b0, 4'h0, 16'h0001, 16'h0001, 16'h0008, 16'h0000);
        pair(16'h0000, 16'h0008, 1'b0, "R6 edge without level");
        pair(16'h0001, 16'h0009, 1'b1, "R6 edge with level");

        // R7: fast mode sweep, level made unsatisfiable to show it is ignored
        for (int pin = 0; pin < 8; pin++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int pc = 0; pc < 4; pc++) begin
                    logic pb, cb, e;
                    pb = pc[1]; cb = pc[0];
                    e  = (pol == 1) ? (pb && !cb) : (!pb && cb);
                    set_cfg(1'b1, {1'(pol), 3'(pin)}, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
                    pair(16'(pb) << pin, 16'(cb) << pin, e, "R7 fast pin edge");
                end
            end
        end

        // R8: invalid cycles do not update the previous sample
        set_cfg(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0010, 16'h0000);
        do_arm();
        send(16'h0000, 1'b0, "R8 first sample");
        data = 16'h0010;
        repeat (3) @(negedge clk);
        check(pulse, 1'b0, "R8 invalid cycles silent");
        send(16'h0010, 1'b1, "R8 edge against last valid sample");

        // R9: latched, no further pulses, re-arm clears
        check(trig, 1'b1, "R9 triggered set");
        check(watch, 1'b0, "R9 watching cleared");
        send(16'h0000, 1'b0, "R9 no pulse after trigger");
        send(16'h0010, 1'b0, "R9 no pulse on new edge");
        check(trig, 1'b1, "R9 triggered held");

        // R11: arm clears, sample in the arm cycle not evaluated
        set_cfg(1'b0, 4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        valid = 1'b1;
        data  = 16'hFFFF;
        do_arm();
        valid = 1'b0;
        check(pulse, 1'b0, "R11 arm-cycle sample ignored");
        check(trig, 1'b0, "R11 triggered cleared");
        check(watch, 1'b1, "R11 watching set");
        send(16'h0000, 1'b1, "R11 level fires after arm");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule